// File: doc/BRIEF.md
# Frequency-Select Watchdog Controller

This block picks the frequency code for a programmable clock generator and guards that choice with a seconds-based watchdog. After reset it captures the five strap select pins once. It holds a software frequency code and an override bit. Its output code comes from the captured straps or from the software code, as the override bit chooses.

Software arms the watchdog by writing a nonzero timeout in whole seconds. The count then falls by one on each one-cycle second tick. When it runs out, the block does not reset anything. Instead it sets a sticky alarm and emits a one-cycle restart pulse. It also reverts the frequency choice: back to the straps, or it keeps the last programmed software code, as a revert-mode bit selects.

Access is through a byte-wide register port with a write strobe and a combinational read. There are three registers:

- address 0 returns the captured straps;
- address 1 holds the software code and the override bit;
- address 2 holds the timeout, the revert mode and the alarm.

Top module: `fsel_wdog`

## Requirements
- R1: While reset is asserted and on release, the override bit, revert bit, alarm bit, timeout field, software code and captured straps are all 0 and `restartPulse` is low.
- R2: Register 0 bits 4:0 hold `strapIn` as sampled on the first rising clock after reset release. Later changes of `strapIn` and writes to register 0 have no effect. Bits 7:5 read 0.
- R3: Register 1 holds the software code in bits 4:0 and the override bit in bit 7, and both are written together. `freqCode` equals the software code when override is 1 and the captured straps when it is 0. Bits 6:5 are ignored on write and read 0.
- R4: Register 2 bits 3:0 are the timeout in seconds. A write of 0 disarms the watchdog. A write of N>0 reloads the count, and expiry happens on the N-th `secTick` after that write. After expiry the watchdog stays idle until the next write.
- R5: On expiry, alarm (register 2 bit 7) becomes 1 and stays 1 through writes with a nonzero timeout. It returns to 0 only when register 2 is written with timeout field 0. Bit 7 of the written data is ignored.
- R6: `restartPulse` is high for exactly one cycle. That cycle follows the clock edge on which the expiring tick was taken.
- R7: Register 2 bit 6 is the revert mode. With 0, expiry clears the override bit so that `freqCode` follows the straps. With 1, override and the software code are left as they were.
- R8: A write to register 2 in the same cycle as an expiring tick wins: the count is reloaded or disarmed, and no expiry occurs.
- R9: When expiry with revert mode 0 falls in the same cycle as a register 1 write, override ends at 0 and the software code takes the written value.
- R10: Reads of the unmapped address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| strapIn | input | 5 | Strap frequency select pins |
| secTick | input | 1 | One-cycle pulse marking one second |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `regAddr`, combinational |
| freqCode | output | 5 | Active frequency code |
| restartPulse | output | 1 | One-cycle pulse on watchdog expiry |

## Verification
The watchdog expiry can coincide with a register write, and the two cases of interest are provoked by driving `secTick` and `wrEn` in the very cycle when one second remains on the count. In the first case the write goes to register 2: the bench expects no restart pulse and a fresh count from the written value, or a cleared alarm when the write disarms. In the second case the write goes to register 1 with revert mode 0: the bench expects the pulse, `freqCode` back on the straps, and register 1 reading back the new code with override clear.

// File: rtl/fsel_wdog_pkg.sv
`timescale 1ns/1ps
package fsel_wdog_pkg;

  // register addresses
  localparam int REG_STRAP = 0;
  localparam int REG_SEL   = 1;
  localparam int REG_WDCTL = 2;

  // field positions
  localparam int SEL_CODE_LSB = 0;
  localparam int SEL_OVR_BIT  = 7;
  localparam int WD_TMO_LSB   = 0;
  localparam int WD_REV_BIT   = 6;
  localparam int WD_ALM_BIT   = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // sample straps this cycle
    logic wrSel;    // register 1 write
    logic wrWd;     // register 2 write
    logic expire;   // watchdog ran out this cycle
  } strobe_t;

endpackage

// File: rtl/fsel_wdog_ctrl.sv
`timescale 1ns/1ps
module fsel_wdog_ctrl
  import fsel_wdog_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int TMO_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [TMO_W-1:0]  tmoIn,
  output strobe_t           strb,
  output logic              capDone,
  output logic              restartPulse
);

  localparam logic [ADDR_W-1:0] A_SEL   = ADDR_W'(REG_SEL);
  localparam logic [ADDR_W-1:0] A_WDCTL = ADDR_W'(REG_WDCTL);
  localparam logic [TMO_W-1:0]  ONE     = TMO_W'(1);

  logic [TMO_W-1:0] cntQ;
  logic             wdWrite;
  logic             selWrite;
  logic             lastSec;

  assign wdWrite  = wrEn && (regAddr == A_WDCTL);
  assign selWrite = wrEn && (regAddr == A_SEL);
  assign lastSec  = secTick && (cntQ == ONE);

  always_comb begin
    strb.capture = !capDone;
    strb.wrSel   = selWrite;
    strb.wrWd    = wdWrite;
    strb.expire  = lastSec && !wdWrite;   // a timeout write takes precedence
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capDone <= 1'b0;
    end else begin
      capDone <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (wdWrite) begin
      cntQ <= tmoIn;
    end else if (secTick && (cntQ != '0)) begin
      cntQ <= cntQ - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      restartPulse <= 1'b0;
    end else begin
      restartPulse <= strb.expire;
    end
  end

endmodule

// File: rtl/fsel_wdog_dp.sv
`timescale 1ns/1ps
module fsel_wdog_dp
  import fsel_wdog_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int CODE_W = 5,
  parameter int TMO_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [CODE_W-1:0] strapIn,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              ovrIn,
  input  logic [TMO_W-1:0]  tmoIn,
  input  logic              revIn,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [CODE_W-1:0] freqCode,
  output logic [CODE_W-1:0] strapQ,
  output logic [CODE_W-1:0] swCodeQ,
  output logic              overrideQ,
  output logic              revertQ,
  output logic              alarmQ,
  output logic [TMO_W-1:0]  tmoQ
);

  localparam logic [ADDR_W-1:0] A_STRAP = ADDR_W'(REG_STRAP);
  localparam logic [ADDR_W-1:0] A_SEL   = ADDR_W'(REG_SEL);
  localparam logic [ADDR_W-1:0] A_WDCTL = ADDR_W'(REG_WDCTL);

  // strap capture, once per reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapQ <= '0;
    end else if (strb.capture) begin
      strapQ <= strapIn;
    end
  end

  // software select register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swCodeQ <= '0;
    end else if (strb.wrSel) begin
      swCodeQ <= codeIn;
    end
  end

  // override: hardware revert beats a software write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrideQ <= 1'b0;
    end else if (strb.expire && !revertQ) begin
      overrideQ <= 1'b0;
    end else if (strb.wrSel) begin
      overrideQ <= ovrIn;
    end
  end

  // watchdog control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmoQ    <= '0;
      revertQ <= 1'b0;
    end else if (strb.wrWd) begin
      tmoQ    <= tmoIn;
      revertQ <= revIn;
    end
  end

  // sticky alarm
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmQ <= 1'b0;
    end else if (strb.wrWd && (tmoIn == '0)) begin
      alarmQ <= 1'b0;
    end else if (strb.expire) begin
      alarmQ <= 1'b1;
    end
  end

  assign freqCode = overrideQ ? swCodeQ : strapQ;

  always_comb begin
    rdData = '0;
    case (regAddr)
      A_STRAP: rdData[CODE_W-1:0] = strapQ;
      A_SEL: begin
        rdData[SEL_CODE_LSB +: CODE_W] = swCodeQ;
        rdData[SEL_OVR_BIT]            = overrideQ;
      end
      A_WDCTL: begin
        rdData[WD_TMO_LSB +: TMO_W] = tmoQ;
        rdData[WD_REV_BIT]          = revertQ;
        rdData[WD_ALM_BIT]          = alarmQ;
      end
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/fsel_wdog.sv
`timescale 1ns/1ps
module fsel_wdog
  import fsel_wdog_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int CODE_W = 5,
  parameter int TMO_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] strapIn,
  input  logic              secTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CODE_W-1:0] freqCode,
  output logic              restartPulse
);

  strobe_t           strb;
  logic              capDone;
  logic [CODE_W-1:0] strapQ;
  logic [CODE_W-1:0] swCodeQ;
  logic              overrideQ;
  logic              revertQ;
  logic              alarmQ;
  logic [TMO_W-1:0]  tmoQ;
  logic [TMO_W-1:0]  tmoIn;
  logic              unusedWr;

  assign tmoIn    = wrData[WD_TMO_LSB +: TMO_W];
  assign unusedWr = ^wrData;

  fsel_wdog_ctrl #(.ADDR_W(ADDR_W), .TMO_W(TMO_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .secTick      (secTick),
    .wrEn         (wrEn),
    .regAddr      (regAddr),
    .tmoIn        (tmoIn),
    .strb         (strb),
    .capDone      (capDone),
    .restartPulse (restartPulse)
  );

  fsel_wdog_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .TMO_W(TMO_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .strapIn   (strapIn),
    .codeIn    (wrData[SEL_CODE_LSB +: CODE_W]),
    .ovrIn     (wrData[SEL_OVR_BIT]),
    .tmoIn     (tmoIn),
    .revIn     (wrData[WD_REV_BIT]),
    .regAddr   (regAddr),
    .rdData    (rdData),
    .freqCode  (freqCode),
    .strapQ    (strapQ),
    .swCodeQ   (swCodeQ),
    .overrideQ (overrideQ),
    .revertQ   (revertQ),
    .alarmQ    (alarmQ),
    .tmoQ      (tmoQ)
  );

endmodule

// File: rtl/fsel_wdog_chk.sv
`timescale 1ns/1ps
module fsel_wdog_chk #(
  parameter int ADDR_W = 2,
  parameter int CODE_W = 5,
  parameter int TMO_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [TMO_W-1:0]  tmoIn,
  input logic              restartPulse,
  input logic              capDone,
  input logic [CODE_W-1:0] strapQ,
  input logic              overrideQ,
  input logic              revertQ,
  input logic              alarmQ,
  input logic [TMO_W-1:0]  tmoQ
);

  localparam logic [ADDR_W-1:0] A_WDCTL = ADDR_W'(fsel_wdog_pkg::REG_WDCTL);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    restartPulse |=> !restartPulse);

  a_r5_alarm_on_expiry: assert property (@(posedge clk) disable iff (!rstN)
    restartPulse |-> alarmQ);

  a_r5_alarm_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (regAddr == A_WDCTL) && (tmoIn == '0)) |=> !alarmQ);

  a_r7_revert_to_straps: assert property (@(posedge clk) disable iff (!rstN)
    (restartPulse && !revertQ) |-> !overrideQ);

  a_r2_strap_held: assert property (@(posedge clk) disable iff (!rstN)
    capDone |=> $stable(strapQ));

  a_r4_idle_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (tmoQ == '0) |=> !restartPulse);

endmodule

bind fsel_wdog fsel_wdog_chk #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .TMO_W(TMO_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .wrEn         (wrEn),
  .regAddr      (regAddr),
  .tmoIn        (tmoIn),
  .restartPulse (restartPulse),
  .capDone      (capDone),
  .strapQ       (strapQ),
  .overrideQ    (overrideQ),
  .revertQ      (revertQ),
  .alarmQ       (alarmQ),
  .tmoQ         (tmoQ)
);

// File: tb/fsel_wdog_bench.sv
`timescale 1ns/1ps
module fsel_wdog_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] strapIn = 5'h16;
  logic       secTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [4:0] freqCode;
  logic       restartPulse;

  int total = 0;
  int bad = 0;
  int pulseCnt = 0;
  int cycles = 0;
  bit done = 0;

  // {write data for register 1, expected readback, expected freqCode}; straps = 0x16
  localparam logic [23:0] SEL_VEC [5] = '{
    {8'h83, 8'h83, 8'h03},
    {8'h03, 8'h03, 8'h16},
    {8'h9F, 8'h9F, 8'h1F},
    {8'hE5, 8'h85, 8'h05},
    {8'h1F, 8'h1F, 8'h16}
  };

  fsel_wdog u_fsel_wdog (
    .clk(clk), .rstN(rstN), .strapIn(strapIn), .secTick(secTick),
    .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData), .rdData(rdData),
    .freqCode(freqCode), .restartPulse(restartPulse)
  );

  always #2 clk = ~clk;

  always @(negedge clk) if (restartPulse) pulseCnt++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired act=%0d exp=<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    #1;
  endtask

  task automatic tick();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
    #1;
  endtask

  task automatic writeWithTick(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d; secTick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; secTick = 1'b0;
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    logic [7:0] d;
    int pre;

    // R1 reset state
    repeat (3) @(negedge clk);
    #1;
    check("R1 restart", {7'd0, restartPulse}, 8'h00);
    check("R1 freq", {3'd0, freqCode}, 8'h00);
    readReg(2'd1, d); check("R1 sel reg", d, 8'h00);
    readReg(2'd2, d); check("R1 wd reg", d, 8'h00);
    readReg(2'd0, d); check("R1 strap reg", d, 8'h00);
    rstN = 1'b1;
    @(negedge clk); #1;

    // R2 strap capture and hold
    readReg(2'd0, d); check("R2 strap captured", d, 8'h16);
    check("R3 freq from straps", {3'd0, freqCode}, 8'h16);
    strapIn = 5'h09;
    @(negedge clk); #1;
    readReg(2'd0, d); check("R2 strap held", d, 8'h16);
    writeReg(2'd0, 8'hFF);
    readReg(2'd0, d); check("R2 strap write ignored", d, 8'h16);
    check("R2 freq after strap write", {3'd0, freqCode}, 8'h16);

    // R3 select table
    for (int i = 0; i < 5; i++) begin
      writeReg(2'd1, SEL_VEC[i][23:16]);
      readReg(2'd1, d); check("R3 sel readback", d, SEL_VEC[i][15:8]);
      check("R3 freq", {3'd0, freqCode}, SEL_VEC[i][7:0]);
    end

    // R10 unmapped
    readReg(2'd3, d); check("R10 unmapped read", d, 8'h00);

    // R4/R6/R7 expiry with revert 0
    writeReg(2'd1, 8'h8A);
    writeReg(2'd2, 8'h03);
    pre = pulseCnt;
    ticks(2);
    check("R4 no early expiry", 8'(pulseCnt - pre), 8'h00);
    tick();
    check("R6 pulse after 3rd tick", {7'd0, restartPulse}, 8'h01);
    readReg(2'd2, d); check("R5 alarm set", d, 8'h83);
    check("R7 freq reverted to straps", {3'd0, freqCode}, 8'h16);
    readReg(2'd1, d); check("R7 override cleared", d, 8'h0A);
    @(negedge clk); #1;
    check("R6 pulse one cycle", {7'd0, restartPulse}, 8'h00);
    ticks(4);
    check("R4 single expiry", 8'(pulseCnt - pre), 8'h01);

    // R5 sticky alarm, bit 7 write ignored
    writeReg(2'd2, 8'h05);
    readReg(2'd2, d); check("R5 alarm sticky", d, 8'h85);
    writeReg(2'd2, 8'h80);
    readReg(2'd2, d); check("R5 alarm cleared by zero timeout", d, 8'h00);

    // R7 revert mode 1 keeps software code
    writeReg(2'd1, 8'h8A);
    writeReg(2'd2, 8'h42);
    ticks(2);
    check("R7 pulse revert1", {7'd0, restartPulse}, 8'h01);
    check("R7 freq kept", {3'd0, freqCode}, 8'h0A);
    readReg(2'd1, d); check("R7 sel kept", d, 8'h8A);
    readReg(2'd2, d); check("R7 wd reg", d, 8'hC2);
    writeReg(2'd2, 8'h00);

    // R4 disabled
    pre = pulseCnt;
    ticks(20);
    check("R4 disabled no pulse", 8'(pulseCnt - pre), 8'h00);

    // R4 reload on rewrite
    writeReg(2'd2, 8'h04);
    ticks(3);
    writeReg(2'd2, 8'h04);
    ticks(3);
    check("R4 reload no pulse", 8'(pulseCnt - pre), 8'h00);
    tick();
    check("R4 reload expiry", {7'd0, restartPulse}, 8'h01);
    writeReg(2'd2, 8'h00);

    // R8 timeout write beats expiring tick
    writeReg(2'd2, 8'h01);
    pre = pulseCnt;
    writeWithTick(2'd2, 8'h05);
    check("R8 reload wins", {7'd0, restartPulse}, 8'h00);
    ticks(4);
    check("R8 no pulse before 5", 8'(pulseCnt - pre), 8'h00);
    tick();
    check("R8 expiry after reload", {7'd0, restartPulse}, 8'h01);
    writeReg(2'd2, 8'h00);
    writeReg(2'd2, 8'h01);
    pre = pulseCnt;
    writeWithTick(2'd2, 8'h00);
    @(negedge clk); #1;
    check("R8 disarm wins", 8'(pulseCnt - pre), 8'h00);
    readReg(2'd2, d); check("R8 alarm stays clear", d, 8'h00);

    // R9 expiry with register 1 write in same cycle
    writeReg(2'd1, 8'h03);
    writeReg(2'd2, 8'h01);
    writeWithTick(2'd1, 8'h8C);
    check("R9 pulse", {7'd0, restartPulse}, 8'h01);
    check("R9 freq on straps", {3'd0, freqCode}, 8'h16);
    readReg(2'd1, d); check("R9 code written override clear", d, 8'h0C);
    readReg(2'd2, d); check("R9 alarm", d, 8'h81);
    writeReg(2'd2, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule